// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on an asynchronous serial line. A host places one character into a holding buffer; the buffer hands it to a shift register the moment that register is idle. The line then carries a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. While one character is being shifted out, the host can already place the next one in the buffer. The two stages are joined without any idle gap between frames.

Two status flags drive two interrupt lines. The buffer-empty flag tells the host that it may write. The transmit-done flag tells the host that the line has gone quiet with nothing pending. Bit timing comes from an external baud tick. A bit lasts 16 ticks, or 8 ticks when the fast mode is selected. Clearing the enable stops new writes, but it does not cut off data that was already handed over.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After synchronous reset, buf_empty_o is 1, done_o is 0, txd_o is 1, line_active_o equals tx_en_i, and both interrupt outputs are 0.
- R2: A write (wr_i high at a clock edge) is taken only when buf_empty_o is 1 and tx_en_i is 1. In any other case it is dropped and never reaches the line.
- R3: When the shift register is idle, an accepted write drops buf_empty_o for exactly one cycle. The start bit (0) appears on txd_o from the second clock edge after the write edge. A character written during a frame moves into the shift register at the edge that ends that frame, so the next start bit follows the last stop bit with no gap.
- R4: A frame is a 0 start bit, then the data bits least significant bit first, then the stop bits as 1. size_i selects the data width: 000=5, 001=6, 010=7, 011=8, 111=9 bits. The other codes give 8 bits. The line idles at 1.
- R5: par_i=10 adds an even parity bit and par_i=11 adds an odd parity bit, placed after the data bits and computed over the transmitted data bits only. Codes 00 and 01 add no parity bit.
- R6: stop2_i=0 sends one stop bit and stop2_i=1 sends two.
- R7: The ninth data bit is taken from a separate register, loaded by b9_wr_i, as it stood when the data byte was written.
- R8: Each bit lasts 16 tick_i pulses when fast_i=0 and 8 when fast_i=1. Without ticks, the current bit does not end.
- R9: done_o rises at the edge that ends the last stop bit if the holding buffer is empty at that edge. It stays 0 between frames sent back to back.
- R10: done_o is cleared by a pulse on done_clr_i or on done_ack_i. A set in the same cycle wins over a clear.
- R11: irq_empty_o = ie_empty_i AND buf_empty_o, and irq_done_o = ie_done_i AND done_o.
- R12: After tx_en_i falls, both the buffered character and the character in the shift register are still sent. line_active_o stays 1 until both stages are empty, and then falls.
- R13: For 5, 6 and 7-bit widths, the upper bits of wr_data_i have no effect on the line, parity included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Baud tick, one pulse per oversample period |
| fast_i | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| tx_en_i | input | 1 | Transmit enable |
| wr_i | input | 1 | Host write strobe for the data byte |
| wr_data_i | input | 8 | Low eight data bits |
| b9_wr_i | input | 1 | Write strobe for the ninth-bit register |
| b9_i | input | 1 | Value for the ninth-bit register |
| size_i | input | 3 | Data width code |
| par_i | input | 2 | Parity code |
| stop2_i | input | 1 | 1 = two stop bits |
| done_clr_i | input | 1 | Write-one clear of done_o |
| done_ack_i | input | 1 | Interrupt acknowledge, clears done_o |
| ie_empty_i | input | 1 | Buffer-empty interrupt enable |
| ie_done_i | input | 1 | Transmit-done interrupt enable |
| txd_o | output | 1 | Serial line |
| line_active_o | output | 1 | 1 while the transmitter owns the line |
| buf_empty_o | output | 1 | Holding buffer can take a write |
| done_o | output | 1 | Transmit-done flag |
| irq_empty_o | output | 1 | Buffer-empty interrupt |
| irq_done_o | output | 1 | Transmit-done interrupt |

## Verification
The holding buffer fills one edge after the write and empties on the next edge when the shifter is idle. The start bit therefore shows two edges after the write edge, and the bench samples buf_empty_o and txd_o on the falling clock edges that follow exactly those edges. A bit then holds for 16 or 8 tick edges, so each bit is sampled near its middle, counted from the first falling edge at which the start bit is seen. done_o and line_active_o change at the edge that ends the last stop bit, and the bench reads them half a bit later. Drop checks wait long enough that a wrongly accepted character would be on the line by then.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

    localparam int MAX_DATA  = 9;
    localparam int MAX_FRAME = 1 + MAX_DATA + 1 + 2;
    localparam int LEN_W     = $clog2(MAX_FRAME + 1);

    typedef enum logic [2:0] {
        SZ_5 = 3'b000,
        SZ_6 = 3'b001,
        SZ_7 = 3'b010,
        SZ_8 = 3'b011,
        SZ_9 = 3'b111
    } size_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_e;

    typedef struct packed {
        logic       b9;
        logic [7:0] lo;
    } char_t;

    typedef struct packed {
        logic [MAX_FRAME-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    function automatic int char_width(logic [2:0] sz);
        case (sz)
            SZ_5:    return 5;
            SZ_6:    return 6;
            SZ_7:    return 7;
            SZ_9:    return 9;
            default: return 8;
        endcase
    endfunction

    // Line order: bit 0 leaves first. Unused positions stay at mark level.
    function automatic frame_t build_frame(char_t c, logic [2:0] sz,
                                           logic [1:0] pm, logic stop2);
        frame_t     f;
        int         w;
        int         pos;
        logic [8:0] d;
        logic       p;
        w       = char_width(sz);
        d       = {c.b9, c.lo};
        f.bits  = '1;
        f.bits[0] = 1'b0;
        p       = (pm == PAR_ODD);
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < w) begin
                f.bits[i+1] = d[i];
                p           = p ^ d[i];
            end
        end
        pos = w + 1;
        if (pm == PAR_EVEN || pm == PAR_ODD) begin
            f.bits[pos[3:0]] = p;
            pos              = pos + 1;
        end
        pos   = pos + 1 + int'(stop2);
        f.len = LEN_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/dbtx_holdbuf.sv
module dbtx_holdbuf
    import dbtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       wr_i,
    input  logic [7:0] wr_data_i,
    input  logic       b9_wr_i,
    input  logic       b9_i,
    input  logic       take_i,
    output logic       full_o,
    output char_t      char_o
);

    logic  full_q;
    logic  b9_q;
    char_t hold_q;
    logic  accept;

    assign accept = wr_i && en_i && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            b9_q   <= 1'b0;
            hold_q <= '0;
        end else begin
            if (b9_wr_i)
                b9_q <= b9_i;
            if (accept) begin
                hold_q <= '{b9: b9_q, lo: wr_data_i};
                full_q <= 1'b1;
            end else if (take_i) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full_o = full_q;
    assign char_o = hold_q;

    // R2: a full buffer is neither overwritten nor lost until taken
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        full_q && !take_i |=> full_q && $stable(hold_q));

    // R3: the shifter only takes from a full buffer
    p_take_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
        take_i |-> full_q);

endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter
    import dbtx_pkg::*;
#(
    parameter int TICKS_NORM = 16,
    parameter int TICKS_FAST = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       fast_i,
    input  logic       full_i,
    input  char_t      char_i,
    input  logic [2:0] size_i,
    input  logic [1:0] par_i,
    input  logic       stop2_i,
    output logic       take_o,
    output logic       busy_o,
    output logic       txd_o,
    output logic       frame_end_o
);

    localparam int TICKS_MAX = (TICKS_NORM > TICKS_FAST) ? TICKS_NORM : TICKS_FAST;
    localparam int CNT_W     = (TICKS_MAX > 2) ? $clog2(TICKS_MAX) : 1;

    logic                 busy_q;
    logic                 fast_q;
    logic [MAX_FRAME-1:0] sh_q;
    logic [LEN_W-1:0]     left_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     lim;
    logic                 bit_end;
    logic                 last_bit;
    frame_t               nxt;

    assign lim         = fast_q ? CNT_W'(TICKS_FAST - 1) : CNT_W'(TICKS_NORM - 1);
    assign bit_end     = busy_q && tick_i && (cnt_q == lim);
    assign last_bit    = (left_q == LEN_W'(1));
    assign frame_end_o = bit_end && last_bit;
    assign take_o      = full_i && (!busy_q || frame_end_o);
    assign nxt         = build_frame(char_i, size_i, par_i, stop2_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            fast_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
            cnt_q  <= '0;
        end else if (take_o) begin
            busy_q <= 1'b1;
            fast_q <= fast_i;
            sh_q   <= nxt.bits;
            left_q <= nxt.len;
            cnt_q  <= '0;
        end else if (bit_end) begin
            cnt_q <= '0;
            if (last_bit) begin
                busy_q <= 1'b0;
            end else begin
                sh_q   <= {1'b1, sh_q[MAX_FRAME-1:1]};
                left_q <= left_q - LEN_W'(1);
            end
        end else if (busy_q && tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign busy_o = busy_q;
    assign txd_o  = !busy_q || sh_q[0];

    // R4: every load begins with a low start bit
    p_start_bit_r4: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !txd_o);

    // R6: a frame holds between 7 and 13 bit slots
    p_frame_len_r6: assert property (@(posedge clk) disable iff (rst)
        take_o |=> (left_q >= LEN_W'(7)) && (left_q <= LEN_W'(MAX_FRAME)));

    // R8: tick count within a bit never passes the selected limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> cnt_q <= lim);

    // R8: without a tick, no progress in the frame
    p_tick_only_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q && !tick_i && !take_o |=> $stable(cnt_q) && $stable(sh_q) && busy_q);

endmodule

// File: rtl/dbtx_status.sv
module dbtx_status (
    input  logic clk,
    input  logic rst,
    input  logic frame_end_i,
    input  logic full_i,
    input  logic clr_i,
    input  logic ack_i,
    input  logic ie_empty_i,
    input  logic ie_done_i,
    output logic done_o,
    output logic irq_empty_o,
    output logic irq_done_o
);

    logic done_q;
    logic set_done;

    assign set_done = frame_end_i && !full_i;

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (set_done)
            done_q <= 1'b1;
        else if (clr_i || ack_i)
            done_q <= 1'b0;
    end

    assign done_o      = done_q;
    assign irq_empty_o = ie_empty_i && !full_i;
    assign irq_done_o  = ie_done_i && done_q;

    // R9: the last stop bit with nothing pending raises done
    p_done_set_r9: assert property (@(posedge clk) disable iff (rst)
        frame_end_i && !full_i |=> done_q);

    // R9: done never rises without a frame ending
    p_done_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(frame_end_i));

    // R10: done holds until cleared or acknowledged
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        done_q && !clr_i && !ack_i |=> done_q);

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
    import dbtx_pkg::*;
#(
    parameter int TICKS_NORM = 16,
    parameter int TICKS_FAST = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       fast_i,
    input  logic       tx_en_i,
    input  logic       wr_i,
    input  logic [7:0] wr_data_i,
    input  logic       b9_wr_i,
    input  logic       b9_i,
    input  logic [2:0] size_i,
    input  logic [1:0] par_i,
    input  logic       stop2_i,
    input  logic       done_clr_i,
    input  logic       done_ack_i,
    input  logic       ie_empty_i,
    input  logic       ie_done_i,
    output logic       txd_o,
    output logic       line_active_o,
    output logic       buf_empty_o,
    output logic       done_o,
    output logic       irq_empty_o,
    output logic       irq_done_o
);

    logic  full;
    logic  take;
    logic  busy;
    logic  frame_end;
    char_t held;

    dbtx_holdbuf u_hold (
        .clk       (clk),
        .rst       (rst),
        .en_i      (tx_en_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .b9_wr_i   (b9_wr_i),
        .b9_i      (b9_i),
        .take_i    (take),
        .full_o    (full),
        .char_o    (held)
    );

    dbtx_shifter #(
        .TICKS_NORM (TICKS_NORM),
        .TICKS_FAST (TICKS_FAST)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .fast_i      (fast_i),
        .full_i      (full),
        .char_i      (held),
        .size_i      (size_i),
        .par_i       (par_i),
        .stop2_i     (stop2_i),
        .take_o      (take),
        .busy_o      (busy),
        .txd_o       (txd_o),
        .frame_end_o (frame_end)
    );

    dbtx_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .frame_end_i (frame_end),
        .full_i      (full),
        .clr_i       (done_clr_i),
        .ack_i       (done_ack_i),
        .ie_empty_i  (ie_empty_i),
        .ie_done_i   (ie_done_i),
        .done_o      (done_o),
        .irq_empty_o (irq_empty_o),
        .irq_done_o  (irq_done_o)
    );

    assign buf_empty_o   = !full;
    assign line_active_o = tx_en_i || full || busy;

    // R12: held data is always drained into the shifter, enabled or not
    p_drain_r12: assert property (@(posedge clk) disable iff (rst)
        full |=> busy);

endmodule

// File: tb/dbuf_serial_tx_test.sv
module dbuf_serial_tx_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick, fast, en, wr, b9wr, b9, stop2, clr, ack, ie_e, ie_d;
    logic [7:0] wdata;
    logic [2:0] size;
    logic [1:0] par;
    logic       txd, line_act, buf_empty, done, irq_e, irq_d;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    dbuf_serial_tx uut (
        .clk (clk), .rst (rst), .tick_i (tick), .fast_i (fast), .tx_en_i (en),
        .wr_i (wr), .wr_data_i (wdata), .b9_wr_i (b9wr), .b9_i (b9),
        .size_i (size), .par_i (par), .stop2_i (stop2),
        .done_clr_i (clr), .done_ack_i (ack), .ie_empty_i (ie_e), .ie_done_i (ie_d),
        .txd_o (txd), .line_active_o (line_act), .buf_empty_o (buf_empty),
        .done_o (done), .irq_empty_o (irq_e), .irq_done_o (irq_d)
    );

    typedef struct packed {
        logic [2:0]  sz;
        logic [1:0]  pm;
        logic        s2;
        logic        fs;
        logic        nb;
        logic [7:0]  d;
        logic [3:0]  n;
        logic [12:0] f;
    } vec_t;

    // expected line order: bit 0 first
    localparam vec_t VECS [7] = '{
        '{3'b011, 2'b00, 1'b0, 1'b0, 1'b0, 8'hA5, 4'd10, 13'({1'b1, 8'hA5, 1'b0})},
        '{3'b000, 2'b10, 1'b1, 1'b0, 1'b0, 8'hFD, 4'd9,  13'({2'b11, 1'b0, 5'b11101, 1'b0})},
        '{3'b001, 2'b11, 1'b0, 1'b0, 1'b0, 8'h2C, 4'd9,  13'({1'b1, 1'b0, 6'b101100, 1'b0})},
        '{3'b010, 2'b10, 1'b0, 1'b0, 1'b0, 8'hC3, 4'd10, 13'({1'b1, 1'b1, 7'b1000011, 1'b0})},
        '{3'b111, 2'b11, 1'b1, 1'b0, 1'b1, 8'h0F, 4'd13, 13'({2'b11, 1'b0, 9'b100001111, 1'b0})},
        '{3'b111, 2'b00, 1'b0, 1'b1, 1'b0, 8'hFF, 4'd11, 13'({1'b1, 9'b011111111, 1'b0})},
        '{3'b011, 2'b11, 1'b1, 1'b0, 1'b0, 8'h00, 4'd12, 13'({2'b11, 1'b1, 8'h00, 1'b0})}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic wr_char(input logic [7:0] d);
        @(negedge clk); wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        while (txd !== 1'b0 && guard < 600) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 600) chk(1'b0, "R3 start bit never seen", 1, 0);
    endtask

    task automatic check_frame(input logic [12:0] exp, input int len, input int t,
                               input string tag);
        logic [12:0] got = '0;
        logic [12:0] msk = '0;
        wait_start();
        repeat (t / 2) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            got[k] = txd;
            msk[k] = 1'b1;
            if (k < len - 1) repeat (t) @(negedge clk);
        end
        chk((got & msk) == (exp & msk), tag, int'(got & msk), int'(exp & msk));
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        rst = 1'b1; tick = 1'b1; fast = 1'b0; en = 1'b0; wr = 1'b0; wdata = '0;
        b9wr = 1'b0; b9 = 1'b0; size = 3'b011; par = 2'b00; stop2 = 1'b0;
        clr = 1'b0; ack = 1'b0; ie_e = 1'b0; ie_d = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(buf_empty === 1'b1, "R1 buf_empty", int'(buf_empty), 1);
        chk(done === 1'b0 && txd === 1'b1, "R1 done/txd", int'({done, txd}), 1);
        chk(line_act === 1'b0 && irq_e === 1'b0 && irq_d === 1'b0, "R1 line/irq",
            int'({line_act, irq_e, irq_d}), 0);

        en = 1'b1;

        // Table walk: R4/R5/R6/R7/R8/R13 frame contents
        foreach (VECS[i]) begin
            @(negedge clk);
            size = VECS[i].sz; par = VECS[i].pm; stop2 = VECS[i].s2; fast = VECS[i].fs;
            b9wr = 1'b1; b9 = VECS[i].nb;
            @(negedge clk); b9wr = 1'b0;
            wr_char(VECS[i].d);
            check_frame(VECS[i].f, int'(VECS[i].n), VECS[i].fs ? 8 : 16,
                        $sformatf("R4/R5/R6/R7/R8/R13 frame vec %0d", i));
            repeat ((VECS[i].fs ? 8 : 16) / 2) @(negedge clk);
            chk(done === 1'b1 && txd === 1'b1, $sformatf("R9 done after vec %0d", i),
                int'({done, txd}), 3);
            pulse_clr();
            chk(done === 1'b0, "R10 write-one clear", int'(done), 0);
        end

        // R3 handoff timing, R2 drop while full, R9 back to back
        size = 3'b011; par = 2'b00; stop2 = 1'b0; fast = 1'b0;
        @(negedge clk); wr = 1'b1; wdata = 8'h5A;
        @(negedge clk); wr = 1'b0;
        chk(buf_empty === 1'b0, "R3 buffer full one edge after write", int'(buf_empty), 0);
        @(negedge clk);
        chk(buf_empty === 1'b1 && txd === 1'b0, "R3 start bit two edges after write",
            int'({buf_empty, txd}), 2);
        wr_char(8'h96);
        chk(buf_empty === 1'b0, "R2 second char held", int'(buf_empty), 0);
        wr_char(8'h00);
        check_frame(13'({1'b1, 8'h5A, 1'b0}), 10, 16, "R3 first frame");
        repeat (10) @(negedge clk);
        chk(done === 1'b0 && txd === 1'b0, "R9 no done between back-to-back frames",
            int'({done, txd}), 0);
        chk(buf_empty === 1'b1, "R3 held char moved at frame end", int'(buf_empty), 1);
        check_frame(13'({1'b1, 8'h96, 1'b0}), 10, 16, "R3 second frame");
        repeat (8) @(negedge clk);
        chk(done === 1'b1, "R9 done after last frame", int'(done), 1);
        repeat (40) @(negedge clk);
        chk(txd === 1'b1 && buf_empty === 1'b1 && done === 1'b1,
            "R2 write while full dropped", int'({txd, buf_empty, done}), 7);

        // R11 interrupts
        ie_e = 1'b1; ie_d = 1'b1;
        @(negedge clk);
        chk(irq_e === 1'b1 && irq_d === 1'b1, "R11 both irqs", int'({irq_e, irq_d}), 3);
        ie_e = 1'b0;
        @(negedge clk);
        chk(irq_e === 1'b0 && irq_d === 1'b1, "R11 empty irq masked", int'({irq_e, irq_d}), 1);

        // R10 acknowledge clears
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk(done === 1'b0 && irq_d === 1'b0, "R10 ack clear", int'({done, irq_d}), 0);

        // R12 deferred disable
        ie_e = 1'b1;
        wr_char(8'h33);
        wr_char(8'hC8);
        chk(irq_e === 1'b0, "R11 empty irq low while full", int'(irq_e), 0);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk(line_act === 1'b1, "R12 line held after disable", int'(line_act), 1);
        check_frame(13'({1'b1, 8'h33, 1'b0}), 10, 16, "R12 pending frame 1");
        chk(line_act === 1'b1, "R12 line held between frames", int'(line_act), 1);
        check_frame(13'({1'b1, 8'hC8, 1'b0}), 10, 16, "R12 pending frame 2");
        repeat (8) @(negedge clk);
        chk(line_act === 1'b0 && buf_empty === 1'b1 && done === 1'b1,
            "R12 released after drain", int'({line_act, buf_empty, done}), 3);
        wr_char(8'h00);
        repeat (40) @(negedge clk);
        chk(txd === 1'b1 && buf_empty === 1'b1, "R2 write while disabled dropped",
            int'({txd, buf_empty}), 3);
        pulse_clr();
        ie_e = 1'b0; ie_d = 1'b0;

        // R8 no ticks, no progress
        en = 1'b1; tick = 1'b0;
        wr_char(8'h55);
        @(negedge clk);
        chk(txd === 1'b0, "R8 start bit loaded without tick", int'(txd), 0);
        repeat (50) @(negedge clk);
        chk(txd === 1'b0 && done === 1'b0, "R8 start bit held without ticks",
            int'({txd, done}), 0);
        tick = 1'b1;
        check_frame(13'({1'b1, 8'h55, 1'b0}), 10, 16, "R8 frame after ticks resume");
        repeat (8) @(negedge clk);
        chk(done === 1'b1, "R9 done after tick-gated frame", int'(done), 1);

        finish_up();
    end

endmodule